// File: doc/BRIEF.md
# DMA Major Loop Completion Controller

This block keeps the outer (major) iteration count of a single DMA channel and runs the end-of-loop sequence once that count is spent. Every time the inner transfer engine finishes one minor loop it pulses `minor_done`. The block then lowers the stored count by one. The count is held either 9 or 15 bits wide, and a channel-link enable picks which.

When a decrement brings the count to zero, the cycle that follows is the completion cycle. In that cycle the block reloads the count from the start value. It also does one of three things. It writes back an adjusted destination address, using a signed adjustment. Or it issues a request to fetch the next 32-byte descriptor. Or, if the fetch address is misaligned, it flags a configuration error. A done flag is also set, and an interrupt is raised if it is enabled. Both stay set until software pulses the clear strobe.

Top module: `dma_major_loop_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it, `citer` is 0, and `dst_addr_out`, `dst_addr_we`, `sg_req`, `sg_addr`, `irq`, `done` and `cfg_err` are all 0.
- R2: A `cfg_load` pulse writes `cfg_citer` (width-limited per R4) into `citer` on the next clock edge. It overrides any `minor_done` in the same cycle.
- R3: A `minor_done` pulse lowers a non-zero `citer` by exactly one, and the new value is visible after the next clock edge.
- R4: With `cfg_link_en`=1 only bits 8:0 of the count exist: loaded and reloaded values keep their low 9 bits and bits 14:9 read 0. With `cfg_link_en`=0 all 15 bits are used.
- R5: If a decrement makes the count 0, the next cycle is the completion cycle. At the end of that cycle `citer` holds `cfg_biter` (width-limited per R4) and `done` is 1.
- R6: In a completion cycle with `cfg_sg_en`=0, `dst_addr_out` becomes `dst_addr_in + cfg_last_adj` modulo 2^32, treating the adjustment as two's complement. `dst_addr_we` pulses high for one cycle.
- R7: In a completion cycle with `cfg_sg_en`=1 and `cfg_last_adj[4:0]`=0, `sg_req` pulses for one cycle and `sg_addr` takes `cfg_last_adj`. `dst_addr_we` stays 0.
- R8: In a completion cycle with `cfg_sg_en`=1 and `cfg_last_adj[4:0]`≠0, `cfg_err` is set. Neither `sg_req` nor `dst_addr_we` pulses, and `sg_addr` keeps its old value.
- R9: A completion sets `irq` when `cfg_int_en`=1 and leaves it unchanged otherwise. `irq` is never 1 while `done` is 0.
- R10: A `minor_done` that arrives when the count is 0 (outside a completion cycle, with no load) sets `cfg_err` and leaves `citer` unchanged.
- R11: `done_clr` clears `done`, `irq` and `cfg_err` on the next edge. A set of any of these flags in the same cycle takes priority over the clear.
- R12: A `minor_done` that arrives during the completion cycle is counted against the reloaded value: `citer` becomes `cfg_biter`-1. If `cfg_biter` is 1, a further completion cycle follows at once.
- R13: With `cfg_biter`=`cfg_citer`=1, the first `minor_done` produces a completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Software strobe that writes `cfg_citer` into the count |
| cfg_citer | input | 15 | Value written into the count by `cfg_load` |
| cfg_biter | input | 15 | Start count, reloaded at completion |
| cfg_link_en | input | 1 | 1 selects the 9-bit count, 0 the 15-bit count |
| cfg_sg_en | input | 1 | 1 fetches the next descriptor at completion, 0 adjusts the address |
| cfg_int_en | input | 1 | Enables the completion interrupt |
| cfg_last_adj | input | 32 | Signed address adjustment, or next-descriptor address |
| done_clr | input | 1 | Software strobe that clears `done`, `irq` and `cfg_err` |
| minor_done | input | 1 | One pulse per finished minor loop |
| dst_addr_in | input | 32 | Current destination address |
| citer | output | 15 | Current major iteration count |
| dst_addr_out | output | 32 | Adjusted destination address |
| dst_addr_we | output | 1 | One-cycle write strobe for `dst_addr_out` |
| sg_req | output | 1 | One-cycle request to fetch the next descriptor |
| sg_addr | output | 32 | Address of the descriptor to fetch |
| irq | output | 1 | Completion interrupt, held until cleared |
| done | output | 1 | Major loop complete flag, held until cleared |
| cfg_err | output | 1 | Configuration error flag, held until cleared |

## Verification
Two collisions need care. The first is a minor-loop pulse that lands in the completion cycle, where the reload and the decrement meet (R12). The second is a software clear that lands in the cycle that sets done or error, where the set must win (R11). The bench provokes the first by holding `minor_done` high across a completion with start counts of 2 and 1, and the second by pulsing `done_clr` exactly in the completion cycle. Random runs also hit both collisions many times. Every cycle, the bench compares all outputs against a cycle model that restates the requirements, so a wrong priority shows up as a mismatch in `citer`, `done` or `cfg_err`.

// File: rtl/dma_mlc_pkg.sv
package dma_mlc_pkg;

  // Action taken in the completion cycle
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ADJ   = 2'd1,
    ACT_FETCH = 2'd2,
    ACT_ERR   = 2'd3
  } mlc_act_e;

endpackage

// File: rtl/mlc_iter_count.sv
module mlc_iter_count #(
  parameter int CNT_W  = 15,
  parameter int LINK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] biter,
  input  logic             link_en,
  input  logic             minor_done,
  output logic [CNT_W-1:0] cnt,
  output logic             fin,
  output logic             zero_err
);

  localparam logic [CNT_W-1:0] LINK_MASK = {{(CNT_W-LINK_W){1'b0}}, {LINK_W{1'b1}}};

  // Keep only the bits that exist in the selected count width
  function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic lnk);
    return lnk ? (v & LINK_MASK) : v;
  endfunction

  logic [CNT_W-1:0] cnt_q, cur, cnt_d;
  logic             fin_q, dec;

  // In the completion cycle the reloaded value is the base for this cycle
  assign cur      = fin_q ? fit(biter, link_en) : cnt_q;
  assign dec      = minor_done && !load && (cur != '0);
  assign zero_err = minor_done && !load && (cur == '0);

  always_comb begin
    if (load)     cnt_d = fit(load_val, link_en);
    else if (dec) cnt_d = cur - 1'b1;
    else          cnt_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fin_q <= dec && (cur == {{(CNT_W-1){1'b0}}, 1'b1});
    end
  end

  assign cnt = cnt_q;
  assign fin = fin_q;

endmodule

// File: rtl/mlc_finish.sv
module mlc_finish
  import dma_mlc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] adj,
  input  logic [ADDR_W-1:0] dst_in,
  output logic [ADDR_W-1:0] dst_out,
  output logic              dst_we,
  output logic              sg_req,
  output logic [ADDR_W-1:0] sg_addr,
  output logic              misalign
);

  // Two's-complement add wraps modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] add_adj(input logic [ADDR_W-1:0] a,
                                                input logic [ADDR_W-1:0] d);
    return a + d;
  endfunction

  function automatic logic is_aligned(input logic [ADDR_W-1:0] a);
    return a[ALIGN_BITS-1:0] == '0;
  endfunction

  mlc_act_e act;

  always_comb begin
    if (!fire)                act = ACT_NONE;
    else if (!sg_en)          act = ACT_ADJ;
    else if (is_aligned(adj)) act = ACT_FETCH;
    else                      act = ACT_ERR;
  end

  assign misalign = (act == ACT_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_out <= '0;
      dst_we  <= 1'b0;
      sg_req  <= 1'b0;
      sg_addr <= '0;
    end else begin
      dst_we <= (act == ACT_ADJ);
      sg_req <= (act == ACT_FETCH);
      if (act == ACT_ADJ)   dst_out <= add_adj(dst_in, adj);
      if (act == ACT_FETCH) sg_addr <= adj;
    end
  end

endmodule

// File: rtl/mlc_status.sv
module mlc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic int_en,
  input  logic err_set,
  input  logic clr,
  output logic done,
  output logic irq,
  output logic err
);

  // A set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      irq  <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (fire)     done <= 1'b1;
      else if (clr) done <= 1'b0;
      if (fire && int_en) irq <= 1'b1;
      else if (clr)       irq <= 1'b0;
      if (err_set)  err <= 1'b1;
      else if (clr) err <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_major_loop_ctrl.sv
module dma_major_loop_ctrl #(
  parameter int CNT_W      = 15,
  parameter int LINK_W     = 9,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_citer,
  input  logic [CNT_W-1:0]  cfg_biter,
  input  logic              cfg_link_en,
  input  logic              cfg_sg_en,
  input  logic              cfg_int_en,
  input  logic [ADDR_W-1:0] cfg_last_adj,
  input  logic              done_clr,
  input  logic              minor_done,
  input  logic [ADDR_W-1:0] dst_addr_in,
  output logic [CNT_W-1:0]  citer,
  output logic [ADDR_W-1:0] dst_addr_out,
  output logic              dst_addr_we,
  output logic              sg_req,
  output logic [ADDR_W-1:0] sg_addr,
  output logic              irq,
  output logic              done,
  output logic              cfg_err
);

  // Named internal events, used by the checker
  logic ev_exhaust;
  logic ev_zero_err;
  logic ev_misalign;

  mlc_iter_count #(.CNT_W(CNT_W), .LINK_W(LINK_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .load_val  (cfg_citer),
    .biter     (cfg_biter),
    .link_en   (cfg_link_en),
    .minor_done(minor_done),
    .cnt       (citer),
    .fin       (ev_exhaust),
    .zero_err  (ev_zero_err)
  );

  mlc_finish #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_finish (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (ev_exhaust),
    .sg_en   (cfg_sg_en),
    .adj     (cfg_last_adj),
    .dst_in  (dst_addr_in),
    .dst_out (dst_addr_out),
    .dst_we  (dst_addr_we),
    .sg_req  (sg_req),
    .sg_addr (sg_addr),
    .misalign(ev_misalign)
  );

  mlc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (ev_exhaust),
    .int_en (cfg_int_en),
    .err_set(ev_zero_err || ev_misalign),
    .clr    (done_clr),
    .done   (done),
    .irq    (irq),
    .err    (cfg_err)
  );

endmodule

// File: rtl/dma_mlc_chk.sv
module dma_mlc_chk #(
  parameter int CNT_W      = 15,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              done_clr,
  input logic              minor_done,
  input logic [CNT_W-1:0]  citer,
  input logic              dst_addr_we,
  input logic              sg_req,
  input logic [ADDR_W-1:0] sg_addr,
  input logic              irq,
  input logic              done,
  input logic              cfg_err,
  input logic              ev_exhaust,
  input logic              ev_zero_err
);

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sg_req && dst_addr_we));

  // R8
  fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_req |-> (sg_addr[ALIGN_BITS-1:0] == '0));

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_err |=> (cfg_err && $stable(citer)));

  // R5
  exhaust_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exhaust |=> done);

  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R11
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !ev_exhaust) |=> !done);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && !cfg_load && !ev_exhaust && citer != '0)
      |=> (citer == $past(citer) - 1'b1));

endmodule

bind dma_major_loop_ctrl dma_mlc_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .done_clr   (done_clr),
  .minor_done (minor_done),
  .citer      (citer),
  .dst_addr_we(dst_addr_we),
  .sg_req     (sg_req),
  .sg_addr    (sg_addr),
  .irq        (irq),
  .done       (done),
  .cfg_err    (cfg_err),
  .ev_exhaust (ev_exhaust),
  .ev_zero_err(ev_zero_err)
);

// File: tb/dma_major_loop_ctrl_bench.sv
`timescale 1ns/1ps
module dma_major_loop_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [14:0] cfg_citer = '0;
  logic [14:0] cfg_biter = '0;
  logic        cfg_link_en = 1'b0;
  logic        cfg_sg_en = 1'b0;
  logic        cfg_int_en = 1'b0;
  logic [31:0] cfg_last_adj = '0;
  logic        done_clr = 1'b0;
  logic        minor_done = 1'b0;
  logic [31:0] dst_addr_in = '0;
  logic [14:0] citer;
  logic [31:0] dst_addr_out;
  logic        dst_addr_we;
  logic        sg_req;
  logic [31:0] sg_addr;
  logic        irq;
  logic        done;
  logic        cfg_err;

  always #2.5 clk = ~clk;

  dma_major_loop_ctrl u_dma_major_loop_ctrl (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Model state
  logic [14:0] m_cnt = '0;
  logic        m_fin = 1'b0;
  logic [31:0] m_dst = '0;
  logic        m_we = 1'b0;
  logic        m_sg = 1'b0;
  logic [31:0] m_sga = '0;
  logic        m_irq = 1'b0;
  logic        m_done = 1'b0;
  logic        m_err = 1'b0;

  // R4: width limit
  function automatic logic [14:0] lim(input logic [14:0] v, input logic lnk);
    return lnk ? {6'b0, v[8:0]} : v;
  endfunction

  // R6: signed adjustment, restated as subtraction of the negated value
  function automatic logic [31:0] adj_dst(input logic [31:0] a, input logic [31:0] d);
    return a - (~d + 32'd1);
  endfunction

  task automatic cmp(input string tag, input string fld, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, fld, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    cmp(tag, "citer(R3)", {17'b0, citer}, {17'b0, m_cnt});
    cmp(tag, "dst_addr_out(R6)", dst_addr_out, m_dst);
    cmp(tag, "dst_addr_we(R6)", {31'b0, dst_addr_we}, {31'b0, m_we});
    cmp(tag, "sg_req(R7)", {31'b0, sg_req}, {31'b0, m_sg});
    cmp(tag, "sg_addr(R7)", sg_addr, m_sga);
    cmp(tag, "irq(R9)", {31'b0, irq}, {31'b0, m_irq});
    cmp(tag, "done(R5)", {31'b0, done}, {31'b0, m_done});
    cmp(tag, "cfg_err(R10)", {31'b0, cfg_err}, {31'b0, m_err});
  endtask

  // Advance model by one edge using current inputs
  task automatic model_edge();
    logic [14:0] cur, ncnt;
    logic err_set, nfin;
    err_set = 1'b0; nfin = 1'b0;
    m_we = 1'b0; m_sg = 1'b0;
    if (m_fin) begin
      if (!cfg_sg_en) begin m_dst = adj_dst(dst_addr_in, cfg_last_adj); m_we = 1'b1; end
      else if (cfg_last_adj[4:0] == 5'd0) begin m_sg = 1'b1; m_sga = cfg_last_adj; end
      else err_set = 1'b1;
    end
    cur = m_fin ? lim(cfg_biter, cfg_link_en) : m_cnt;
    ncnt = cur;
    if (cfg_load) ncnt = lim(cfg_citer, cfg_link_en);
    else if (minor_done) begin
      if (cur == 15'd0) err_set = 1'b1;
      else begin ncnt = cur - 15'd1; nfin = (cur == 15'd1); end
    end
    if (m_fin) m_done = 1'b1; else if (done_clr) m_done = 1'b0;
    if (m_fin && cfg_int_en) m_irq = 1'b1; else if (done_clr) m_irq = 1'b0;
    if (err_set) m_err = 1'b1; else if (done_clr) m_err = 1'b0;
    m_cnt = ncnt;
    m_fin = nfin;
  endtask

  // Inputs are set at the falling edge; outputs checked 1 ns after the rising edge
  task automatic step(input string tag);
    model_edge();
    @(posedge clk);
    #1;
    cmp_all(tag);
    @(negedge clk);
    cfg_load = 1'b0;
    minor_done = 1'b0;
    done_clr = 1'b0;
  endtask

  task automatic setup(input logic [14:0] b, input logic lnk, input logic sg,
                       input logic ie, input logic [31:0] adj);
    cfg_biter = b; cfg_citer = b; cfg_link_en = lnk; cfg_sg_en = sg;
    cfg_int_en = ie; cfg_last_adj = adj; cfg_load = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    cmp_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1 after reset");

    // R2: load wins over minor_done
    setup(15'd5, 1'b0, 1'b0, 1'b0, 32'd0); minor_done = 1'b1; step("R2 load priority");
    minor_done = 1'b1; step("R3 decrement");
    done_clr = 1'b1; step("R11 clear idle");

    // R13 + R6 negative adjustment + R9
    setup(15'd1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFF0); step("R13 setup");
    dst_addr_in = 32'h0000_1008;
    minor_done = 1'b1; step("R13 single request");
    step("R6 R5 completion");
    step("R9 irq held");
    // R11: clear in the completion cycle, set wins
    minor_done = 1'b1; step("R13 again");
    done_clr = 1'b1; step("R11 set wins");
    done_clr = 1'b1; step("R11 clear");

    // R10: zero count
    cfg_citer = 15'd0; cfg_load = 1'b1; step("R10 load zero");
    minor_done = 1'b1; step("R10 zero err");
    done_clr = 1'b1; step("R11 clear err");

    // R8: misaligned fetch address
    setup(15'd1, 1'b0, 1'b1, 1'b0, 32'h2000_0044); step("R8 setup");
    minor_done = 1'b1; step("R8 exhaust");
    step("R8 misaligned");
    done_clr = 1'b1; step("R8 clear");

    // R7: aligned fetch
    setup(15'd1, 1'b0, 1'b1, 1'b1, 32'h2000_0060); step("R7 setup");
    minor_done = 1'b1; step("R7 exhaust");
    step("R7 fetch");
    done_clr = 1'b1; step("R7 clear");

    // R4: 9-bit count
    setup(15'h0203, 1'b1, 1'b0, 1'b0, 32'd4); cfg_citer = 15'h7FFF; step("R4 load masked");
    cfg_citer = 15'h0201; cfg_load = 1'b1; step("R4 load small");
    minor_done = 1'b1; step("R4 to zero");
    step("R4 reload masked");

    // R12: minor_done held through completion, biter 2 then 1
    setup(15'd2, 1'b0, 1'b0, 1'b0, 32'd32); step("R12 setup");
    for (int i = 0; i < 6; i++) begin minor_done = 1'b1; step("R12 collision b2"); end
    setup(15'd1, 1'b0, 1'b0, 1'b1, 32'd32); step("R12 setup b1");
    for (int i = 0; i < 5; i++) begin minor_done = 1'b1; step("R12 collision b1"); end
    done_clr = 1'b1; step("R12 clear");

    // Random episodes
    for (int ep = 0; ep < 80; ep++) begin
      logic [14:0] b;
      b = 15'($urandom_range(1, 6));
      if ($urandom_range(0, 3) == 0) b = b | 15'h0400;
      setup(b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)),
            ($urandom_range(0, 2) == 0) ? $urandom() : ($urandom() & 32'hFFFF_FFE0));
      step("R2 random load");
      for (int c = 0; c < 40; c++) begin
        minor_done = 1'($urandom_range(0, 1));
        done_clr = ($urandom_range(0, 9) == 0);
        dst_addr_in = $urandom();
        step("R12 random");
      end
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule